// File: doc/BRIEF.md
# Stream Trace Monitor

This block watches a valid/ready packet stream carrying video and control packets, and it never drives any of that stream's signals. For each packet it builds a short summary record. The record holds the packet type, the length of the packet in cycles, and three flow counts: the cycles that moved data, the cycles where the source had nothing to offer, and the cycles where the sink held the source back. It also holds the idle time since the previous packet. Pixel payloads are not kept. For control packets, the first few words are copied into the record so that their contents can be read later.

Records leave the block as consecutive 32-bit words on a valid/ready output, and a trace collector downstream accepts them. The monitor has no buffer of its own for queued records. If a packet ends while the previous record is still being sent, the new record is discarded. The next record that does go out carries a flag that reports the loss.

Top module: `strm_trace_mon`

## Requirements
- R1: A packet opens on a cycle with valid and ready high and the start marker set while no packet is open, and it closes on the cycle with valid and ready high and the end marker set. Beats outside a packet without a start marker are ignored. Word 1 bits 15:0 hold the number of cycles from the opening cycle to the closing cycle, inclusive.
- R2: Word 2 bits 15:0 hold the number of cycles inside the packet with valid and ready both high.
- R3: Word 3 bits 15:0 hold the number of cycles inside the packet with valid low.
- R4: Word 4 bits 15:0 hold the number of cycles inside the packet with valid high and ready low.
- R5: Word 5 bits 15:0 hold the number of cycles strictly between the previous packet's closing cycle (or reset release) and the opening cycle. This includes cycles where a start beat was offered but not accepted.
- R6: Word 0 bits 3:0 carry the low four data bits of the opening beat as the packet type. Type 0 (video) gives a 6-word record.
- R7: A nonzero type gives a 10-word record. Words 6 to 9 hold the data of the first four accepted beats of the packet, and zero for any beat the packet did not have.
- R8: Every count saturates at 16'hFFFF instead of wrapping.
- R9: The first record word is offered on the cycle after the closing cycle. The words follow in index order, the last flag marks only the final word, and each word stays valid and unchanged while the collector holds ready low.
- R10: A packet that closes while a record is still being sent (a record whose final word is accepted on that same edge counts as still being sent) yields no record. The next record sent has word 0 bit 31 set, and the records after that have it clear.
- R11: During and right after reset no record word is offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_valid | input | 1 | Observed stream valid |
| mon_ready | input | 1 | Observed stream ready |
| mon_sop | input | 1 | Observed start-of-packet marker |
| mon_eop | input | 1 | Observed end-of-packet marker |
| mon_data | input | DATA_W | Observed stream data |
| rec_valid | output | 1 | Record word offered |
| rec_ready | input | 1 | Collector accepts the record word |
| rec_data | output | 32 | Record word |
| rec_last | output | 1 | Final word of the record |

## Verification
The monitor is driven with four kinds of packet:
- **Clean video packet.** Every beat transfers, so the counts can show only transfers. A packet with starved source cycles and a packet with backpressured cycles follow it, and between them they separate the not-valid count from the not-ready count.
- **Control packets of different lengths.** Packets with more than four beats, with fewer than four beats and with a single beat separate correct capture from zero fill and from late overwrites.
- **Two packets back to back.** With the collector fast, the second packet closes while the first record is still being sent, which shows the drop and the single-use loss flag. With the collector stalled, the record words can be seen to hold.
- **Very long starved packet after a very long idle stretch.** This distinguishes saturating counts from wrapping ones.

// File: rtl/trace_mon_pkg.sv
`timescale 1ns/1ps
package trace_mon_pkg;
  // record word width and header layout; downstream decoding depends on these indices
  localparam int REC_W    = 32;
  localparam int HDR_N    = 6;
  localparam int W_HDR    = 0;
  localparam int W_FIRST  = 1;   // first statistics word
  localparam int W_GAP    = 5;
  localparam int LOST_BIT = REC_W - 1;

  // statistics counter slots, in record order starting at W_FIRST
  localparam int ST_SPAN  = 0;
  localparam int ST_XFER  = 1;
  localparam int ST_NOVAL = 2;
  localparam int ST_NORDY = 3;
  localparam int N_STAT   = 4;
endpackage

// File: rtl/tm_sat_cnt.sv
`timescale 1ns/1ps
module tm_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt
);

  always_comb begin
    q_nxt = q;
    if (en) begin
      if (clr)
        q_nxt = W'(inc);
      else if (inc && (q != {W{1'b1}}))
        q_nxt = q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (en)
      q <= q_nxt;
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && inc && (q == {W{1'b1}})) |=> (q == {W{1'b1}})); // R8

endmodule

// File: rtl/tm_pkt_track.sv
`timescale 1ns/1ps
module tm_pkt_track #(
  parameter int DATA_W = 32,
  parameter int TYPE_W = 4,
  parameter int CAP_N  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid,
  input  logic                    ready,
  input  logic                    sop,
  input  logic                    eop,
  input  logic [DATA_W-1:0]       data,
  output logic                    start,
  output logic                    active,
  output logic                    pkt_end,
  output logic [TYPE_W-1:0]       type_nxt,
  output logic [CAP_N*DATA_W-1:0] cap_nxt
);

  localparam int BIDX_W = $clog2(CAP_N + 1);

  logic              in_pkt, in_pkt_nxt;
  logic              xfer, body_xfer;
  logic [BIDX_W-1:0] bidx, bidx_nxt;
  logic [TYPE_W-1:0] type_q;
  logic [DATA_W-1:0] cap_q [CAP_N];

  always_comb begin
    xfer      = valid & ready;
    start     = !in_pkt & xfer & sop;
    active    = in_pkt | start;
    pkt_end   = active & xfer & eop;
    body_xfer = in_pkt & xfer;
    if (pkt_end)    in_pkt_nxt = 1'b0;
    else if (start) in_pkt_nxt = 1'b1;
    else            in_pkt_nxt = in_pkt;
    type_nxt = start ? data[TYPE_W-1:0] : type_q;
    if (start)
      bidx_nxt = BIDX_W'(1);
    else if (body_xfer && (bidx < BIDX_W'(CAP_N)))
      bidx_nxt = bidx + BIDX_W'(1);
    else
      bidx_nxt = bidx;
  end

  generate
    for (genvar i = 0; i < CAP_N; i++) begin : g_cap
      always_comb begin
        if (start)
          cap_nxt[i*DATA_W +: DATA_W] = (i == 0) ? data : '0;
        else if (body_xfer && (bidx == BIDX_W'(i)))
          cap_nxt[i*DATA_W +: DATA_W] = data;
        else
          cap_nxt[i*DATA_W +: DATA_W] = cap_q[i];
      end

      always_ff @(posedge clk) begin
        if (active)
          cap_q[i] <= cap_nxt[i*DATA_W +: DATA_W];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      bidx   <= '0;
    end else begin
      in_pkt <= in_pkt_nxt;
      if (active) bidx <= bidx_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (start) type_q <= type_nxt;
  end

  AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !in_pkt); // R1
  AST_OPEN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pkt_end) |=> in_pkt); // R1

endmodule

// File: rtl/tm_rec_ser.sv
`timescale 1ns/1ps
module tm_rec_ser
  import trace_mon_pkg::*;
#(
  parameter int WORDS = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [WORDS*REC_W-1:0]        words,
  input  logic [$clog2(WORDS)-1:0]      last_idx,
  input  logic                          rec_ready,
  output logic                          rec_valid,
  output logic [REC_W-1:0]              rec_data,
  output logic                          rec_last
);

  localparam int IDX_W = $clog2(WORDS);

  logic             busy, busy_nxt;
  logic             lost_pend, lost_nxt;
  logic [IDX_W-1:0] idx, idx_nxt, end_idx;
  logic [REC_W-1:0] word_q [WORDS];
  logic [REC_W-1:0] hdr_w;
  logic             fire, accept, drop;

  always_comb begin
    fire     = busy & rec_ready;
    accept   = load & !busy;
    drop     = load & busy;
    rec_valid = busy;
    rec_data  = word_q[idx];
    rec_last  = busy & (idx == end_idx);
    hdr_w           = words[REC_W-1:0];
    hdr_w[LOST_BIT] = lost_pend;
    if (accept)                 busy_nxt = 1'b1;
    else if (fire && rec_last)  busy_nxt = 1'b0;
    else                        busy_nxt = busy;
    if (accept)                 idx_nxt = '0;
    else if (fire && !rec_last) idx_nxt = idx + IDX_W'(1);
    else                        idx_nxt = idx;
    if (drop)        lost_nxt = 1'b1;
    else if (accept) lost_nxt = 1'b0;
    else             lost_nxt = lost_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      lost_pend <= 1'b0;
    end else begin
      busy      <= busy_nxt;
      idx       <= idx_nxt;
      lost_pend <= lost_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      end_idx   <= last_idx;
      word_q[0] <= hdr_w;
      for (int i = 1; i < WORDS; i++)
        word_q[i] <= words[i*REC_W +: REC_W];
    end
  end

  AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data) && $stable(rec_last))); // R9
  AST_REC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rec_valid && (idx == '0))); // R9
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> lost_pend); // R10
  AST_FLAG_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !drop) |=> !lost_pend); // R10

endmodule

// File: rtl/strm_trace_mon.sv
`timescale 1ns/1ps
module strm_trace_mon
  import trace_mon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int CAP_N  = 4,
  parameter int TYPE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_valid,
  input  logic              mon_ready,
  input  logic              mon_sop,
  input  logic              mon_eop,
  input  logic [DATA_W-1:0] mon_data,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [REC_W-1:0]  rec_data,
  output logic              rec_last
);

  localparam int REC_N = HDR_N + CAP_N;
  localparam int IDX_W = $clog2(REC_N);

  logic                    trk_start, trk_active, trk_end;
  logic [TYPE_W-1:0]       pkt_type;
  logic [CAP_N*DATA_W-1:0] cap_flat;
  logic [N_STAT-1:0]       stat_inc;
  logic [CNT_W-1:0]        stat_q   [N_STAT];
  logic [CNT_W-1:0]        stat_nxt [N_STAT];
  logic [CNT_W-1:0]        gap_q, gap_nxt, gap_hold, gap_rec;
  logic [REC_N*REC_W-1:0]  rec_flat;
  logic [IDX_W-1:0]        rec_end_idx;

  tm_pkt_track #(
    .DATA_W (DATA_W),
    .TYPE_W (TYPE_W),
    .CAP_N  (CAP_N)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (mon_valid),
    .ready    (mon_ready),
    .sop      (mon_sop),
    .eop      (mon_eop),
    .data     (mon_data),
    .start    (trk_start),
    .active   (trk_active),
    .pkt_end  (trk_end),
    .type_nxt (pkt_type),
    .cap_nxt  (cap_flat)
  );

  always_comb begin
    stat_inc[ST_SPAN]  = 1'b1;
    stat_inc[ST_XFER]  = mon_valid & mon_ready;
    stat_inc[ST_NOVAL] = !mon_valid;
    stat_inc[ST_NORDY] = mon_valid & !mon_ready;
  end

  generate
    for (genvar g = 0; g < N_STAT; g++) begin : g_stat
      tm_sat_cnt #(.W(CNT_W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (trk_active),
        .clr   (trk_start),
        .inc   (stat_inc[g]),
        .q     (stat_q[g]),
        .q_nxt (stat_nxt[g])
      );
    end
  endgenerate

  tm_sat_cnt #(.W(CNT_W)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .clr   (trk_start),
    .inc   (!trk_active),
    .q     (gap_q),
    .q_nxt (gap_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gap_hold <= '0;
    else if (trk_start)
      gap_hold <= gap_q;
  end

  always_comb begin
    gap_rec  = trk_start ? gap_q : gap_hold;
    rec_flat = '0;
    rec_flat[W_HDR*REC_W +: REC_W] = REC_W'(pkt_type);
    for (int i = 0; i < N_STAT; i++)
      rec_flat[(W_FIRST+i)*REC_W +: REC_W] = REC_W'(stat_nxt[i]);
    rec_flat[W_GAP*REC_W +: REC_W] = REC_W'(gap_rec);
    for (int i = 0; i < CAP_N; i++)
      rec_flat[(HDR_N+i)*REC_W +: REC_W] = REC_W'(cap_flat[i*DATA_W +: DATA_W]);
    rec_end_idx = (pkt_type != '0) ? IDX_W'(REC_N-1) : IDX_W'(HDR_N-1);
  end

  tm_rec_ser #(.WORDS(REC_N)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (trk_end),
    .words     (rec_flat),
    .last_idx  (rec_end_idx),
    .rec_ready (rec_ready),
    .rec_valid (rec_valid),
    .rec_data  (rec_data),
    .rec_last  (rec_last)
  );

  AST_XFER_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    trk_active |-> (stat_nxt[ST_XFER] <= stat_nxt[ST_SPAN])); // R2
  AST_STALLS_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_active && (stat_q[ST_SPAN] != {CNT_W{1'b1}})) |->
      ({1'b0, stat_q[ST_NOVAL]} + {1'b0, stat_q[ST_NORDY]} <= {1'b0, stat_q[ST_SPAN]})); // R3
  AST_GAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    trk_active |-> (gap_nxt == '0)); // R5
  AST_NO_REC_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rec_valid); // R11

endmodule

// File: tb/strm_trace_mon_tb.sv
`timescale 1ns/1ps
module strm_trace_mon_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mon_valid, mon_ready, mon_sop, mon_eop;
  logic [31:0] mon_data;
  logic        rec_valid, rec_ready, rec_last;
  logic [31:0] rec_data;

  always #2.5 clk = ~clk;

  strm_trace_mon u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_valid (mon_valid),
    .mon_ready (mon_ready),
    .mon_sop   (mon_sop),
    .mon_eop   (mon_eop),
    .mon_data  (mon_data),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_data  (rec_data),
    .rec_last  (rec_last)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // collector: takes words at the falling edge, before the rising edge that accepts them
  logic [31:0] got_w [$];
  logic        got_l [$];
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rec_valid === 1'b1 && rec_ready === 1'b1) begin
      got_w.push_back(rec_data);
      got_l.push_back(rec_last);
    end
  end

  // reference model of the record contents, built from the requirements
  bit          m_in, m_lost, m_drop;
  logic [15:0] m_span, m_x, m_nv, m_nr, m_gap, m_gh;
  logic [3:0]  m_type;
  logic [31:0] m_cap [4];
  int          m_b;
  logic [31:0] exp_w [$];
  int          exp_n [$];

  function automatic logic [15:0] sinc(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  task automatic emit();
    if (m_drop) begin
      m_lost = 1'b1;
      m_drop = 1'b0;
    end else begin
      exp_w.push_back({m_lost, 27'd0, m_type});
      exp_w.push_back({16'd0, m_span});
      exp_w.push_back({16'd0, m_x});
      exp_w.push_back({16'd0, m_nv});
      exp_w.push_back({16'd0, m_nr});
      exp_w.push_back({16'd0, m_gh});
      if (m_type != 4'd0) begin
        for (int k = 0; k < 4; k++) exp_w.push_back(m_cap[k]);
        exp_n.push_back(10);
      end else begin
        exp_n.push_back(6);
      end
      m_lost = 1'b0;
    end
  endtask

  // one stream cycle: drive, model, then advance past the next rising edge
  task automatic step(input bit v, input bit r, input bit s, input bit e, input logic [31:0] d);
    bit xf, st, act;
    mon_valid = v; mon_ready = r; mon_sop = s; mon_eop = e; mon_data = d;
    xf  = v && r;
    st  = !m_in && xf && s;
    act = m_in || st;
    if (st) begin
      m_gh = m_gap; m_gap = 16'd0;
      m_span = 16'd0; m_x = 16'd0; m_nv = 16'd0; m_nr = 16'd0;
      m_type = d[3:0]; m_b = 0;
      for (int k = 0; k < 4; k++) m_cap[k] = 32'd0;
    end
    if (act) begin
      m_span = sinc(m_span);
      if (xf) m_x = sinc(m_x);
      if (!v) m_nv = sinc(m_nv);
      if (v && !r) m_nr = sinc(m_nr);
      if (xf && m_b < 4) begin m_cap[m_b] = d; m_b++; end
      if (xf && e) begin emit(); m_in = 1'b0; end
      else m_in = 1'b1;
    end else begin
      m_gap = sinc(m_gap);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 1, 0, 0, 32'd0);
  endtask

  function automatic string tag_of(input int k);
    case (k)
      0: return "R6 R10 header";
      1: return "R1 span";
      2: return "R2 transfers";
      3: return "R3 not-valid";
      4: return "R4 not-ready";
      5: return "R5 gap";
      default: return "R7 capture";
    endcase
  endfunction

  // compare every expected record against the collected words
  task automatic drain();
    while (exp_n.size() > 0) begin
      int n, waited;
      n = exp_n.pop_front();
      waited = 0;
      while (got_w.size() < n && waited < 200) begin idle(1); waited++; end
      chk_eq("R9 record word count", 32'(got_w.size() >= n), 32'd1);
      for (int k = 0; k < n; k++) begin
        logic [31:0] e;
        e = exp_w.pop_front();
        if (got_w.size() > 0) begin
          chk_eq(tag_of(k), got_w.pop_front(), e);
          chk_eq("R9 last flag", 32'(got_l.pop_front()), 32'(k == n - 1));
        end
      end
    end
    idle(12);
    chk_eq("R10 no extra record words", 32'(got_w.size()), 32'd0);
    got_w.delete();
    got_l.delete();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rec_ready = 1'b1;
    mon_valid = 0; mon_ready = 0; mon_sop = 0; mon_eop = 0; mon_data = 0;
    m_in = 0; m_lost = 0; m_drop = 0; m_gap = 0; m_gh = 0;
    repeat (3) @(posedge clk);
    #1;
    chk_eq("R11 valid low in reset", 32'(rec_valid), 32'd0);
    rst_n = 1'b1;
    idle(2);
    chk_eq("R11 valid low after reset", 32'(rec_valid), 32'd0);
  endtask

  task automatic t_video_clean();
    // stray beats without a start marker: ignored
    step(1, 1, 0, 0, 32'h0000_0003);
    step(1, 1, 0, 1, 32'h0000_0005);
    idle(1);
    chk_eq("R1 stray beats ignored", 32'(rec_valid), 32'd0);
    step(1, 1, 1, 0, 32'hABCD_0010);
    step(1, 1, 0, 0, 32'h1111_1111);
    step(1, 1, 0, 0, 32'h2222_2222);
    step(1, 1, 0, 1, 32'h3333_3333);
    chk_eq("R9 first word next cycle", 32'(rec_valid), 32'd1);
    drain();
  endtask

  task automatic t_video_flow();
    step(1, 0, 1, 0, 32'h0000_0000);   // start offered, not accepted: gap
    step(1, 0, 1, 0, 32'h0000_0000);
    step(1, 1, 1, 0, 32'h0000_0000);
    step(0, 1, 0, 0, 32'h0);
    step(0, 0, 0, 0, 32'h0);
    step(1, 0, 0, 0, 32'h4);
    step(1, 0, 0, 0, 32'h4);
    step(1, 0, 0, 0, 32'h4);
    step(1, 1, 0, 0, 32'h4);
    step(0, 1, 0, 0, 32'h0);
    step(1, 0, 0, 1, 32'h5);
    step(1, 1, 0, 1, 32'h5);
    drain();
  endtask

  task automatic t_ctrl_long();
    step(1, 1, 1, 0, 32'hC0DE_0003);
    step(1, 0, 0, 0, 32'hAAAA_0001);
    step(1, 1, 0, 0, 32'hAAAA_0001);
    step(0, 1, 0, 0, 32'h0);
    step(1, 1, 0, 0, 32'hAAAA_0002);
    step(1, 1, 0, 0, 32'hAAAA_0003);
    step(1, 1, 0, 0, 32'hAAAA_0004);
    step(1, 1, 0, 1, 32'hAAAA_0005);
    drain();
  endtask

  task automatic t_ctrl_short();
    step(1, 1, 1, 0, 32'h1234_567F);
    step(1, 1, 0, 1, 32'h89AB_CDEF);
    drain();
    step(1, 1, 1, 1, 32'h5555_AAA2);   // one-beat control packet
    drain();
  endtask

  task automatic t_stall();
    logic [31:0] held;
    rec_ready = 1'b0;
    step(1, 1, 1, 0, 32'h0000_0000);
    step(1, 1, 0, 1, 32'h0000_0001);
    chk_eq("R9 valid after close", 32'(rec_valid), 32'd1);
    held = rec_data;
    idle(3);
    chk_eq("R9 valid held", 32'(rec_valid), 32'd1);
    chk_eq("R9 data held", rec_data, held);
    rec_ready = 1'b1;
    drain();
  endtask

  task automatic t_drop();
    step(1, 1, 1, 1, 32'h0000_0000);   // record A accepted
    m_drop = 1'b1;
    step(1, 1, 1, 1, 32'h0000_0000);   // record B dropped: output busy
    drain();
    idle(2);
    step(1, 1, 1, 0, 32'h0000_0009);   // record C carries the loss flag
    step(1, 1, 0, 1, 32'h7777_7777);
    drain();
    step(1, 1, 1, 1, 32'h0000_0000);   // record D: flag clear again
    drain();
  endtask

  task automatic t_sat();
    idle(65600);                        // gap beyond the count range
    step(1, 1, 1, 0, 32'h0000_0000);
    for (int k = 0; k < 70000; k++) step(0, 1, 0, 0, 32'h0);
    step(1, 1, 0, 1, 32'h0);
    drain();
    chk_eq("R8 model saturated", 32'(m_nv), 32'h0000_FFFF);
  endtask

  initial begin
    #950000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_video_clean();
    t_video_flow();
    t_ctrl_long();
    t_ctrl_short();
    t_stall();
    t_drop();
    t_sat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule